// File: doc/BRIEF.md
# I2C SCL Bit Timing Generator

This block paces the serial clock of a register-programmed I2C master. From a speed-mode code, a baud word and a setup count, it works out how long the clock is driven low and how long it is released. It gives a bit-level engine a baud tick and one-cycle strobes at the start of each low phase and at the start of each released phase. It drives the clock low only during the low phase. Whenever the line is released it watches the sampled clock level.

A target may keep the clock low after the master releases it. While that lasts, high-phase counting is frozen. When the line finally rises, an extra setup delay runs before high-phase counting resumes. That setup delay is programmed as a cycle count plus one, so zero still costs one cycle. The low half of the baud word sets the base period. The upper half is reserved for a high-speed counter and is ignored. Standard timing splits the clock period into two equal baud periods. Fast timing splits it into three: two low, one high.

Top module: `bt_scl_timing`

## Requirements
- R1: During and right after reset, with run low, `scl_low_o`, `fall_o`, `rise_o`, `setup_o` and `tick_o` are all 0.
- R2: Mode code 0 (standard): each low phase lasts P clock cycles and each released phase lasts P cycles when nobody stretches. P is `baud_word_i[15:0]`.
- R3: Mode codes 1 (fast) and 3 (fast plus): each low phase lasts 2·P cycles and each released phase lasts P cycles.
- R4: Mode code 2 (high speed, not supported) falls back to standard timing: low P, released P.
- R5: A baud count of zero acts as one, so P = 1 and the generator keeps running.
- R6: `baud_word_i[31:16]` has no effect on any timing.
- R7: If the line stays low for S ≥ 1 cycles after release, high-phase counting holds for those cycles. The released phase then lasts S + (setup_cnt_i + 1) + P cycles. `setup_o` is high for setup_cnt_i of those cycles. With S = 0, no setup delay is applied.
- R8: A setup count of zero still waits one cycle after a stretch: the released phase lasts S + 1 + P.
- R9: `fall_o` pulses for exactly the first cycle of every low phase, and `rise_o` for the first cycle of every released phase. The two never coincide.
- R10: When `run_i` drops, the clock is released on the next cycle and no further low phase starts.
- R11: `tick_o` pulses once at the end of each baud period while counting. A low phase therefore holds 1 tick in standard timing and 2 in fast timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| run_i | input | 1 | Generate clock phases while high |
| mode_i | input | 2 | Speed code: 0 standard, 1 fast, 2 high speed, 3 fast plus |
| baud_word_i | input | 32 | Low half: baud count P; upper half reserved, ignored |
| setup_cnt_i | input | 16 | Post-stretch setup delay, in cycles minus one |
| scl_in_i | input | 1 | Sampled level of the SCL line |
| scl_low_o | output | 1 | Drive SCL low |
| tick_o | output | 1 | End of a baud period |
| fall_o | output | 1 | First cycle of a low phase |
| rise_o | output | 1 | First cycle of a released phase |
| setup_o | output | 1 | Post-stretch setup delay in progress |

## Verification
Each stimulus pattern runs the clock and measures the lengths of the low and released phases. Mode codes 0, 1, 2 and 3 are tried with different baud counts. This separates the 1:1 split from the 2:1 split, and shows the high-speed fallback. A zero baud count and a baud word with a non-zero upper half show that the degenerate count is clamped and that the reserved half is ignored. Stretch patterns vary the stretch length and the setup count, including zero and a setup count with no stretch. These separate the held count, the plus-one setup rule and the bypass when no stretch occurs. Directed checks cover the reset state and dropping run in the middle of a low phase.

// File: rtl/i2c_bt_pkg.sv
package i2c_bt_pkg;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_LOW   = 2'd1,
        PH_HIGH  = 2'd2,
        PH_SETUP = 2'd3
    } phase_e;

    localparam logic [1:0] MODE_STD   = 2'd0;
    localparam logic [1:0] MODE_FAST  = 2'd1;
    localparam logic [1:0] MODE_HS    = 2'd2;
    localparam logic [1:0] MODE_FPLUS = 2'd3;

    // Baud periods spent low: two for the divide-by-three modes, else one.
    function automatic logic [1:0] low_ticks(input logic [1:0] mode);
        return (mode == MODE_FAST || mode == MODE_FPLUS) ? 2'd2 : 2'd1;
    endfunction

    typedef struct packed {
        phase_e     phase;
        logic [1:0] tk;
        logic       stretched;
        logic       fall;
        logic       rise;
    } ctl_t;

endpackage

// File: rtl/bt_baud_prescaler.sv
module bt_baud_prescaler #(
    parameter int W = 16
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic         clr_i,
    input  logic         en_i,
    input  logic [W-1:0] period_i,
    output logic         tick_o
);

    logic [W-1:0] cnt_d, cnt_q;
    logic [W-1:0] last;

    always_comb begin
        // A zero period is clamped to a single cycle.
        last   = (period_i == '0) ? '0 : period_i - 1'b1;
        tick_o = en_i && !clr_i && (cnt_q == last);
        cnt_d  = cnt_q;
        if (clr_i) begin
            cnt_d = '0;
        end else if (en_i) begin
            cnt_d = tick_o ? '0 : cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) cnt_q <= '0;
        else         cnt_q <= cnt_d;
    end

    AST_TICK_GAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (tick_o && last != '0) |=> (!tick_o || !$stable(period_i))); // R11

endmodule

// File: rtl/bt_setup_timer.sv
module bt_setup_timer #(
    parameter int W = 16
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic         run_i,
    input  logic [W-1:0] limit_i,
    output logic         done_o
);

    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        done_o = run_i && (({1'b0, cnt_q} + 1'b1) == {1'b0, limit_i});
        cnt_d  = run_i ? cnt_q + 1'b1 : '0;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) cnt_q <= '0;
        else         cnt_q <= cnt_d;
    end

    AST_SETUP_LIMIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        run_i |-> (limit_i != '0)); // R8

    AST_SETUP_EXIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |=> !run_i); // R7

endmodule

// File: rtl/bt_scl_timing.sv
module bt_scl_timing
    import i2c_bt_pkg::*;
#(
    parameter int BAUD_W  = 16,
    parameter int SETUP_W = 16
) (
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic                run_i,
    input  logic [1:0]          mode_i,
    input  logic [2*BAUD_W-1:0] baud_word_i,
    input  logic [SETUP_W-1:0]  setup_cnt_i,
    input  logic                scl_in_i,
    output logic                scl_low_o,
    output logic                tick_o,
    output logic                fall_o,
    output logic                rise_o,
    output logic                setup_o
);

    localparam int WORD_W = 2 * BAUD_W;

    ctl_t q, d;

    logic [BAUD_W-1:0] base_cnt;
    logic [1:0]        lt;
    logic              pre_en, pre_clr, pre_tick;
    logic              detect, setup_run, setup_done;

    // Only the low half sets the base period; the upper half is reserved.
    assign base_cnt  = baud_word_i[BAUD_W-1:0];
    assign setup_run = (q.phase == PH_SETUP);

    bt_baud_prescaler #(.W(BAUD_W)) i_pre (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .clr_i    (pre_clr),
        .en_i     (pre_en),
        .period_i (base_cnt),
        .tick_o   (pre_tick)
    );

    bt_setup_timer #(.W(SETUP_W)) i_setup (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .run_i   (setup_run),
        .limit_i (setup_cnt_i),
        .done_o  (setup_done)
    );

    always_comb begin
        lt      = low_ticks(mode_i);
        detect  = (q.phase == PH_HIGH) && scl_in_i && q.stretched;
        pre_en  = (q.phase == PH_LOW) ||
                  ((q.phase == PH_HIGH) && scl_in_i && !q.stretched);
        pre_clr = (q.phase == PH_IDLE) || (q.phase == PH_SETUP) || detect;

        d = q;
        unique case (q.phase)
            PH_IDLE: begin
                if (run_i) begin
                    d.phase = PH_LOW;
                    d.tk    = '0;
                end
            end
            PH_LOW: begin
                if (pre_tick) begin
                    if (q.tk == lt - 2'd1) begin
                        d.phase     = PH_HIGH;
                        d.tk        = '0;
                        d.stretched = 1'b0;
                    end else begin
                        d.tk = q.tk + 2'd1;
                    end
                end
            end
            PH_HIGH: begin
                if (!scl_in_i) begin
                    // Line still low after release: hold the count.
                    d.stretched = 1'b1;
                end else if (q.stretched) begin
                    // This cycle is the first setup cycle.
                    d.stretched = 1'b0;
                    if (setup_cnt_i != '0) d.phase = PH_SETUP;
                end else if (pre_tick) begin
                    d.phase = PH_LOW;
                    d.tk    = '0;
                end
            end
            PH_SETUP: begin
                if (setup_done) d.phase = PH_HIGH;
            end
            default: d.phase = PH_IDLE;
        endcase

        if (!run_i) begin
            d.phase     = PH_IDLE;
            d.tk        = '0;
            d.stretched = 1'b0;
        end

        d.fall = (d.phase == PH_LOW)  && (q.phase != PH_LOW);
        d.rise = (d.phase == PH_HIGH) && (q.phase == PH_LOW);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            q <= '{phase: PH_IDLE, tk: 2'd0, stretched: 1'b0,
                   fall: 1'b0, rise: 1'b0};
        end else begin
            q <= d;
        end
    end

    assign scl_low_o = (q.phase == PH_LOW);
    assign tick_o    = pre_tick;
    assign fall_o    = q.fall;
    assign rise_o    = q.rise;
    assign setup_o   = setup_run;

    AST_FALL_ON_ENTRY: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(scl_low_o) |-> fall_o); // R9

    AST_STROBE_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(fall_o && rise_o)); // R9

    AST_RUN_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !run_i |=> !scl_low_o); // R10

    AST_STRETCH_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((q.phase == PH_HIGH) && !scl_in_i) |-> !tick_o); // R7

    AST_SETUP_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
        setup_o |-> (!scl_low_o && !tick_o)); // R7

    AST_WORD_WIDTH: assert property (@(posedge clk_i) disable iff (!rst_ni)
        fall_o |-> $past(run_i)); // R10

    if (WORD_W < 2) begin : g_bad_width
        initial $display("bt_scl_timing: BAUD_W too small");
    end

endmodule

// File: tb/test_bt_scl_timing.sv
module test_bt_scl_timing;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        run = 1'b0;
    logic [1:0]  mode = 2'd0;
    logic [31:0] baud_word = 32'd4;
    logic [15:0] setup_cnt = 16'd0;
    logic        scl_in;
    logic        scl_low, tick, fall, rise, setup_act;

    int n_cmp = 0;
    int n_bad = 0;
    int hold_cnt = 0;
    int stretch_len = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    assign scl_in = !(scl_low || hold_cnt != 0);

    bt_scl_timing i_bt_scl_timing (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .run_i       (run),
        .mode_i      (mode),
        .baud_word_i (baud_word),
        .setup_cnt_i (setup_cnt),
        .scl_in_i    (scl_in),
        .scl_low_o   (scl_low),
        .tick_o      (tick),
        .fall_o      (fall),
        .rise_o      (rise),
        .setup_o     (setup_act)
    );

    // Target model: keeps SCL low for stretch_len cycles after each release.
    initial forever begin
        @(negedge clk);
        if (scl_low)           hold_cnt = stretch_len + 1;
        else if (hold_cnt > 0) hold_cnt = hold_cnt - 1;
    end

    task automatic chk(input string req, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // mode | baud word | setup | stretch | exp low | exp released | req
    localparam int NV = 11;
    localparam logic [97:0] VEC [NV] = '{
        {2'd0, 32'h0000_0004, 16'd0, 8'd0, 16'd4,  16'd4,  8'd2},  // R2
        {2'd0, 32'h0000_0007, 16'd0, 8'd0, 16'd7,  16'd7,  8'd2},  // R2
        {2'd1, 32'h0000_0003, 16'd0, 8'd0, 16'd6,  16'd3,  8'd3},  // R3
        {2'd3, 32'h0000_0005, 16'd0, 8'd0, 16'd10, 16'd5,  8'd3},  // R3
        {2'd2, 32'h0000_0003, 16'd0, 8'd0, 16'd3,  16'd3,  8'd4},  // R4
        {2'd0, 32'h0000_0000, 16'd0, 8'd0, 16'd1,  16'd1,  8'd5},  // R5
        {2'd1, 32'h0000_0000, 16'd0, 8'd0, 16'd2,  16'd1,  8'd5},  // R5
        {2'd0, 32'hABCD_0004, 16'd0, 8'd0, 16'd4,  16'd4,  8'd6},  // R6
        {2'd0, 32'h0000_0004, 16'd3, 8'd5, 16'd4,  16'd13, 8'd7},  // R7
        {2'd1, 32'h0000_0002, 16'd6, 8'd1, 16'd4,  16'd10, 8'd7},  // R7
        {2'd1, 32'h0000_0003, 16'd0, 8'd2, 16'd6,  16'd6,  8'd8}   // R8
    };

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        chk("R1", {scl_low, fall, rise, setup_act, tick}, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk("R1", {scl_low, fall, rise, setup_act, tick}, 0);

        for (int v = 0; v < NV; v++) begin
            logic [97:0] e;
            int lo, hi, tk, st, exp_lt, exp_st;
            string tag;
            e = VEC[v];
            tag = $sformatf("R%0d", e[7:0]);
            mode = e[97:96];
            baud_word = e[95:64];
            setup_cnt = e[63:48];
            stretch_len = int'(e[47:40]);
            exp_lt = (mode == 2'd1 || mode == 2'd3) ? 2 : 1;
            exp_st = (stretch_len > 0 && setup_cnt != 0) ? int'(setup_cnt) : 0;
            run = 1'b1;
            @(negedge clk);
            while (!fall) @(negedge clk);
            lo = 0; tk = 0;
            while (scl_low) begin
                lo++;
                if (tick) tk++;
                @(negedge clk);
            end
            chk("R9", int'(rise), 1);          // R9 rise on first released cycle
            hi = 0; st = 0;
            while (!scl_low) begin
                hi++;
                if (setup_act) st++;
                @(negedge clk);
            end
            chk("R9", int'(fall), 1);          // R9 fall on next low phase
            chk(tag, lo, int'(e[39:24]));
            chk(tag, hi, int'(e[23:8]));
            chk("R11", tk, exp_lt);            // R11 ticks per low phase
            chk("R7", st, exp_st);             // R7 setup cycles seen
            run = 1'b0;
            repeat (4) @(negedge clk);
        end

        // R7: setup count ignored when nobody stretches
        mode = 2'd0; baud_word = 32'd3; setup_cnt = 16'd9; stretch_len = 0;
        run = 1'b1;
        @(negedge clk);
        while (!fall) @(negedge clk);
        while (scl_low) @(negedge clk);
        begin
            int hi = 0;
            while (!scl_low) begin hi++; @(negedge clk); end
            chk("R7", hi, 3);
        end
        run = 1'b0;
        repeat (4) @(negedge clk);

        // R10: run dropped in the middle of a low phase
        mode = 2'd0; baud_word = 32'd20; setup_cnt = 16'd0;
        run = 1'b1;
        @(negedge clk);
        while (!fall) @(negedge clk);
        repeat (5) @(negedge clk);
        chk("R10", int'(scl_low), 1);
        run = 1'b0;
        @(negedge clk);
        chk("R10", int'(scl_low), 0);
        begin
            int nf = 0;
            for (int i = 0; i < 40; i++) begin
                if (fall || scl_low) nf++;
                @(negedge clk);
            end
            chk("R10", nf, 0);
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule